// File: doc/BRIEF.md
# Serial Hex Command Memory Controller

This block sits between a byte-level serial receiver/transmitter pair and a small synchronous memory. It reads typed ASCII characters and turns them into memory cycles, so a plain terminal can inspect and patch memory contents. Internally it keeps a data register and an address register. Typed hex digits accumulate in the data register. Two punctuation characters act as commands: one loads the address and reads memory, and the other writes memory.

A read command copies the data register into the address register. It then issues a one-cycle read, captures the returned word into the data register, and sends the word back as two upper-case hex characters followed by carriage return and line feed. A write command stores the low byte of the data register at the current address. When the `AUTO_INC` parameter is set, the address then advances by one, so consecutive writes fill successive locations. Bytes that are not commands are flagged on an error output. The block samples received bytes only while it is idle.

Top module: `hexcmd_ctrl`

## Requirements
- R1: A received hex digit shifts its 4-bit value into the low end of the 16-bit data register, and the older contents move up 4 bits (the top nibble is lost). Hex digits are ASCII 0x30-0x39 ('0'-'9'), 0x41-0x46 ('A'-'F') and 0x61-0x66 ('a'-'f').
- R2: On 0x2F ('/') received in idle, the data register is copied to the address register. In the next cycle `mem_re` is high for exactly one cycle, with `mem_addr` equal to the copied value.
- R3: `mem_rdata` is captured in the cycle after `mem_re` and loaded, zero-extended, into the data register.
- R4: After a read, the block transmits exactly four bytes: the upper-case ASCII hex of bits 7:4 of the read word, then of bits 3:0, then 0x0D, then 0x0A.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R6: On 0x24 ('$') received in idle, `mem_we` is high for one cycle in the next cycle. In that cycle `mem_addr` holds the address register and `mem_wdata` holds the low 8 bits of the data register.
- R7: With `AUTO_INC`=1 (the default), the address register increases by one after each write. With `AUTO_INC`=0 it is left unchanged.
- R8: Any other byte received in idle sets `cmd_err` in the next cycle. It starts no memory cycle and leaves both registers unchanged.
- R9: `cmd_err` stays set until reset or until a hex digit, '/' or '$' is accepted, which clears it.
- R10: Bytes received while a read, reply or write is in progress are dropped. They do not change the registers or `cmd_err`.
- R11: After reset, `tx_valid`, `mem_we`, `mem_re` and `cmd_err` are low, and the address and data registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter accepts the current byte |
| tx_valid | output | 1 | Byte to transmit is present |
| tx_data | output | 8 | Byte to transmit |
| mem_addr | output | 16 | Memory address (address register) |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_re` |
| cmd_err | output | 1 | Unrecognised character seen |

## Verification
The hardest case to reach is a byte that arrives while the block is not idle, because a careful sender always waits for the reply. The stimulus issues a read without waiting for it to finish. It then drives a hex digit while the read word is being captured, and an illegal character while the reply is being sent, with `tx_ready` throttled by a pseudo-random pattern. A later write shows that the data register was untouched, and `cmd_err` is checked to confirm it stayed clear. Back-to-back writes with no digits between them expose the address step, and a five-digit entry shows the top nibble falling off the register.

// File: rtl/hexcmd_pkg.sv
package hexcmd_pkg;

  typedef enum logic [1:0] {
    CH_HEX,
    CH_LOAD,
    CH_STORE,
    CH_BAD
  } ch_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ISSUE,
    ST_RD_CAPT,
    ST_REPLY,
    ST_WR
  } st_t;

  localparam logic [7:0] ASC_LOAD  = 8'h2F;
  localparam logic [7:0] ASC_STORE = 8'h24;
  localparam logic [7:0] ASC_CR    = 8'h0D;
  localparam logic [7:0] ASC_LF    = 8'h0A;

  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

endpackage

// File: rtl/hexcmd_decode.sv
module hexcmd_decode
  import hexcmd_pkg::*;
(
  input  logic [7:0] ch,
  output ch_kind_t   kind,
  output logic [3:0] nib
);

  always_comb begin
    kind = CH_BAD;
    nib  = ch[3:0];
    if (ch >= 8'h30 && ch <= 8'h39) begin
      kind = CH_HEX;
    end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
      kind = CH_HEX;
      nib  = ch[3:0] + 4'd9;
    end else if (ch == ASC_LOAD) begin
      kind = CH_LOAD;
    end else if (ch == ASC_STORE) begin
      kind = CH_STORE;
    end
  end

endmodule

// File: rtl/hexcmd_reply.sv
module hexcmd_reply
  import hexcmd_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data
);

  localparam int NDIG  = (WORD_W + 3) / 4;
  localparam int HW    = NDIG * 4;
  localparam int NCHAR = NDIG + 2;
  localparam int IW    = $clog2(NCHAR);
  localparam logic [IW-1:0] CR_IDX = IW'(NDIG);
  localparam logic [IW-1:0] LAST   = IW'(NCHAR - 1);

  logic [HW-1:0] held;
  logic [HW-1:0] wpad;
  logic [HW-1:0] held_sh;
  logic [IW-1:0] idx;
  logic [IW-1:0] idx_nx;

  assign wpad    = HW'(word);
  assign held_sh = held << 4;
  assign idx_nx  = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= '0;
      idx      <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (start) begin
      held     <= wpad;
      idx      <= '0;
      tx_valid <= 1'b1;
      tx_data  <= nib_to_ascii(wpad[HW-1 -: 4]);
    end else if (tx_valid && tx_ready) begin
      if (idx == LAST) begin
        tx_valid <= 1'b0;
      end else begin
        idx  <= idx_nx;
        held <= held_sh;
        if (idx_nx < CR_IDX)       tx_data <= nib_to_ascii(held_sh[HW-1 -: 4]);
        else if (idx_nx == CR_IDX) tx_data <= ASC_CR;
        else                       tx_data <= ASC_LF;
      end
    end
  end

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_reply_ends_lf_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_valid) |-> ($past(tx_data) == ASC_LF));

endmodule

// File: rtl/hexcmd_ctrl.sv
module hexcmd_ctrl
  import hexcmd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int MEM_W    = 8,
  parameter bit AUTO_INC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [MEM_W-1:0]  mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [MEM_W-1:0]  mem_rdata,
  output logic              cmd_err
);

  localparam int INC_STEP = AUTO_INC ? 1 : 0;

  st_t               state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_after_wr;
  ch_kind_t          kind;
  logic [3:0]        nib;
  logic              reply_start;

  hexcmd_decode u_dec (
    .ch   (rx_data),
    .kind (kind),
    .nib  (nib)
  );

  generate
    if (AUTO_INC) begin : g_inc
      assign addr_after_wr = addr_q + 1'b1;
    end else begin : g_hold
      assign addr_after_wr = addr_q;
    end
  endgenerate

  assign reply_start = (state == ST_RD_CAPT);
  assign mem_addr    = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      data_q    <= '0;
      cmd_err   <= 1'b0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (rx_valid) begin
            unique case (kind)
              CH_HEX: begin
                data_q  <= {data_q[DATA_W-5:0], nib};
                cmd_err <= 1'b0;
              end
              CH_LOAD: begin
                addr_q  <= ADDR_W'(data_q);
                mem_re  <= 1'b1;
                cmd_err <= 1'b0;
                state   <= ST_RD_ISSUE;
              end
              CH_STORE: begin
                mem_we    <= 1'b1;
                mem_wdata <= data_q[MEM_W-1:0];
                cmd_err   <= 1'b0;
                state     <= ST_WR;
              end
              default: cmd_err <= 1'b1;
            endcase
          end
        end
        ST_RD_ISSUE: state <= ST_RD_CAPT;
        ST_RD_CAPT: begin
          data_q <= DATA_W'(mem_rdata);
          state  <= ST_REPLY;
        end
        ST_REPLY: begin
          if (!tx_valid) state <= ST_IDLE;
        end
        ST_WR: begin
          addr_q <= addr_after_wr;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  hexcmd_reply #(.WORD_W(MEM_W)) u_reply (
    .clk      (clk),
    .rst      (rst),
    .start    (reply_start),
    .word     (mem_rdata),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  assert_load_reads_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && rx_valid && rx_data == ASC_LOAD)
      |=> (mem_re && mem_addr == ADDR_W'($past(data_q))));

  assert_re_single_R2: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (!mem_re && !mem_we));

  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    $past(mem_re, 2) |-> (data_q == DATA_W'($past(mem_rdata))));

  assert_store_writes_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && rx_valid && rx_data == ASC_STORE)
      |=> (mem_we && mem_wdata == $past(data_q[MEM_W-1:0])));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (mem_addr == $past(mem_addr) + ADDR_W'(INC_STEP)));

  assert_bad_char_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && rx_valid && kind == CH_BAD)
      |=> (cmd_err && !mem_we && !mem_re && $stable(addr_q) && $stable(data_q)));

  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(cmd_err));

endmodule

// File: tb/sim_hexcmd_ctrl.sv
module sim_hexcmd_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        tx_ready = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        mem_re;
  logic [7:0]  mem_rdata = 8'h00;
  logic        cmd_err;

  always #10 clk = ~clk;

  hexcmd_ctrl u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .cmd_err(cmd_err)
  );

  logic [7:0] ram    [0:255];
  logic [7:0] shadow [0:255];

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
  end

  logic [7:0] lfsr = 8'hA7;
  always @(posedge clk) begin
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= lfsr[0] | lfsr[3];
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [23:0] exp_wr[$];
  logic [7:0]  exp_tx[$];

  logic [15:0] m_data = 16'h0;
  logic [15:0] m_addr = 16'h0;
  bit          m_err  = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit bhex(input logic [7:0] c, output logic [3:0] v);
    v = 4'h0;
    if (c >= 8'h30 && c <= 8'h39) begin v = c[3:0]; return 1'b1; end
    if ((c >= 8'h41 && c <= 8'h46) || (c >= 8'h61 && c <= 8'h66)) begin
      v = c[3:0] + 4'd9; return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [7:0] basc(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h41 + {4'h0, n} - 8'd10);
  endfunction

  // scoreboard monitor
  bit         stall_prev = 1'b0;
  logic [7:0] data_prev  = 8'h00;
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_prev)
        check(tx_valid && tx_data == data_prev, "R5", "tx held while stalled",
              32'({tx_valid, tx_data}), 32'({1'b1, data_prev}));
      stall_prev = tx_valid && !tx_ready;
      data_prev  = tx_data;
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) check(1'b0, "R4", "unexpected tx byte", 32'(tx_data), 32'h0);
        else begin
          automatic logic [7:0] e = exp_tx.pop_front();
          check(tx_data == e, "R4", "reply byte", 32'(tx_data), 32'(e));
        end
      end
      if (mem_we) begin
        if (exp_wr.size() == 0) check(1'b0, "R6", "unexpected write", 32'({mem_addr, mem_wdata}), 32'h0);
        else begin
          automatic logic [23:0] w = exp_wr.pop_front();
          check({mem_addr, mem_wdata} == w, "R6", "write addr/data", 32'({mem_addr, mem_wdata}), 32'(w));
        end
      end
      if (mem_we && mem_re) check(1'b0, "R2", "read and write together", 32'h3, 32'h0);
    end
  end

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (exp_tx.size() != 0 || exp_wr.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit live, input bit wait_done);
    logic [3:0]  v;
    logic [15:0] a0;
    logic [15:0] d0;
    logic [7:0]  rd;
    bit          is_h;
    is_h = bhex(b, v);
    a0 = m_addr;
    d0 = m_data;
    if (live) begin
      if (is_h) begin
        m_data = {m_data[11:0], v}; m_err = 1'b0;
      end else if (b == 8'h2F) begin
        m_addr = m_data;
        rd = shadow[m_addr[7:0]];
        m_data = {8'h00, rd};
        exp_tx.push_back(basc(rd[7:4]));
        exp_tx.push_back(basc(rd[3:0]));
        exp_tx.push_back(8'h0D);
        exp_tx.push_back(8'h0A);
        m_err = 1'b0;
      end else if (b == 8'h24) begin
        exp_wr.push_back({m_addr, m_data[7:0]});
        shadow[m_addr[7:0]] = m_data[7:0];
        m_addr = m_addr + 16'd1;
        m_err = 1'b0;
      end else begin
        m_err = 1'b1;
      end
    end
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    if (!live) begin
      check(cmd_err == m_err && !mem_re && !mem_we, "R10", "busy byte dropped",
            32'({cmd_err, mem_re, mem_we}), 32'({m_err, 2'b00}));
    end else if (is_h) begin
      check(!cmd_err && !mem_re && !mem_we, "R1", "digit: no error, no cycle",
            32'({cmd_err, mem_re, mem_we}), 32'h0);
    end else if (b == 8'h2F) begin
      check(mem_re && mem_addr == m_addr, "R2", "read issued at copied address",
            32'({mem_re, mem_addr}), 32'({1'b1, m_addr}));
    end else if (b == 8'h24) begin
      check(mem_we && mem_addr == a0 && mem_wdata == d0[7:0], "R6", "write cycle",
            32'({mem_we, mem_addr, mem_wdata}), 32'({1'b1, a0, d0[7:0]}));
    end else begin
      check(cmd_err && !mem_re && !mem_we, "R8", "bad char flags error only",
            32'({cmd_err, mem_re, mem_we}), 32'h4);
    end
    if (wait_done) wait_idle();
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send(s[i], 1'b1, 1'b1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i]    = 8'(i * 37 + 11) ^ 8'hA5;
      shadow[i] = 8'(i * 37 + 11) ^ 8'hA5;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state of outputs
    check(!tx_valid && !mem_we && !mem_re && !cmd_err && mem_addr == 16'h0, "R11", "reset outputs",
          32'({tx_valid, mem_we, mem_re, cmd_err, mem_addr}), 32'h0);
    // R11: data register zero after reset, written to address 0
    send_str("$");
    // R1: five digits, top nibble drops; R2/R4 read and reply
    send_str("12345/");
    check(mem_addr == 16'h2345, "R1", "address after 5 digits", 32'(mem_addr), 32'h2345);
    // R3: captured read word written back; R7: second write one address up
    send_str("$");
    check(mem_addr == 16'h2346, "R7", "address stepped after write", 32'(mem_addr), 32'h2346);
    send_str("$");
    // R1: lower-case digits
    send_str("a5$");
    send_str("Fc/");
    // R8/R9: bad characters set and keep the error, valid command clears it
    send_str("G");
    send_str("x");
    check(cmd_err, "R9", "error kept across second bad char", 32'(cmd_err), 32'h1);
    send_str("$");
    check(!cmd_err, "R9", "error cleared by command", 32'(cmd_err), 32'h0);
    // read back a written location: expect "A5\r\n"
    send_str("2347/");
    // R10: bytes during read capture and reply are dropped
    send(8'h2F, 1'b1, 1'b0);
    send(8'h37, 1'b0, 1'b0);
    send(8'h5A, 1'b0, 1'b0);
    wait_idle();
    send_str("$");
    send_str("BEEF90/");
    send_str("Q");
    send_str("7$");
    check(exp_tx.size() == 0 && exp_wr.size() == 0, "R4", "all expected items seen",
          32'(exp_tx.size() + exp_wr.size()), 32'h0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule